// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Unit

This block sits between a register bus and the shift engine of a clocked serial port. It holds one transmit queue and one receive queue of 32 bytes each. Software fills the transmit queue and drains the receive queue through data windows in a small register map. The shift engine takes transmit words and hands over receive words through valid/ready channels. In byte mode an entry is one byte, so a queue holds 32 entries. In word mode an entry is a 16-bit word, so a queue holds 16 entries.

The unit raises a single interrupt line. A status register collects six conditions: a receive threshold that can be programmed as a power of two, the transmit queue running dry, transfer end, shift end, receive overflow and transmit underrun. Software clears the sticky bits by writing 1s to them. An enable bit in the control register at the same bit position masks each one onto the interrupt. A soft-reset bit in the control register empties both queues and clears the sticky status.

Channel rules. The transmit channel is `tx_valid`/`tx_ready`: a word leaves on a cycle where both are high, and `tx_valid` is high whenever the transmit queue holds data. The shift engine cannot stall, so the receive channel has no real back-pressure. `rx_ready` is low only while the receive queue is full. A beat offered with `rx_ready` low is lost and is reported as overflow.

Register word addresses on `reg_addr`: 0 control, 1 status, 2 trigger code, 3 transmit level, 4 receive level, 5 transmit data, 6 receive data. Register reads are combinational on `reg_rdata`. Any side effect of a read or write takes place at the clock edge where `reg_rd` or `reg_wr` is high.

Top module: `spi_fifo_irq`

## Requirements
- R1: Both queues are first-in first-out. A queue accepts 32 entries when `wide_mode`=0 and 16 entries when `wide_mode`=1. In byte mode only bits [7:0] are stored, and in word mode bits [15:0] are stored. A push into a full queue is dropped and leaves the stored entries unchanged. This holds even when a pop happens in the same cycle.
- R2: Reading address 3 or 4 returns the entry count of the transmit or receive queue, and both counts are 0 after reset. Writing 0 there empties that queue. Writing a nonzero value there has no effect.
- R3: Status bit 0 is a live bit and writes do not clear it. It reads 1 only when two conditions both hold: control bit 16 is set, and the receive count is at least 2^T, where T is bits [2:0] of address 2.
- R4: Status bit 4 is set when a transmit-channel handshake removes the last transmit entry.
- R5: Status bit 12 is set when `rx_valid` is high while `rx_ready` is low. The offered word is discarded.
- R6: Status bit 13 is set when `send_mode`=1, `tx_ready`=1 and the transmit queue is empty. With `send_mode`=0 this condition sets nothing.
- R7: A one-cycle pulse on `xfer_end_evt` sets status bit 8. A one-cycle pulse on `shift_end_evt` sets status bit 9.
- R8: Writing address 1 clears every sticky status bit (4, 8, 9, 12, 13) whose write bit is 1. If a bit is set and cleared in the same cycle, the set takes effect.
- R9: `irq` is high exactly when some status bit at position 0, 4, 8, 9, 12 or 13 is set and the control bit at the same position is also set.
- R10: While control bit 28 is 1, both queues are held empty, pushes are dropped and the sticky status bits are held at 0. The control register itself keeps its value.
- R11: Reading address 6 pops the receive queue. When the receive queue is empty, this read returns 0 and the count does not change. Reading address 5 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive data window) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| wide_mode | input | 1 | 1 = 16-bit entries, 0 = byte entries |
| send_mode | input | 1 | Engine is transmitting; enables underrun detection |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Engine takes or requests a transmit word |
| tx_data | output | 16 | Head of transmit queue, 0 when empty |
| rx_valid | input | 1 | Engine delivers a receive word |
| rx_ready | output | 1 | Receive queue not full |
| rx_data | input | 16 | Received word |
| xfer_end_evt | input | 1 | Transfer-end pulse from the engine |
| shift_end_evt | input | 1 | Shift-end pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the capacity boundary in both entry widths, including a push into a full queue. A design that counts bytes instead of entries, or wraps its pointer, would report a wrong level or hand out a stale word. It moves the receive count across the programmed power-of-two threshold and tries to clear the live trigger bit by writing it; an off-by-one comparison or a sticky implementation shows up as a wrong status or interrupt. It collides a status write-1-clear with a set pulse in the same cycle, where a design that gives priority to the clear would lose the event. It also checks that the soft reset and a zero level write empty the queues, while a nonzero level write and a pop from an empty queue leave the state untouched.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_TRIG   = 3'd2,
    A_TXLVL  = 3'd3,
    A_RXLVL  = 3'd4,
    A_TXDATA = 3'd5,
    A_RXDATA = 3'd6
  } reg_addr_e;

  // status / enable bit positions (shared by status and control)
  localparam int B_RXTRG = 0;
  localparam int B_TXTRG = 4;
  localparam int B_XEND  = 8;
  localparam int B_SEND  = 9;
  localparam int B_OVF   = 12;
  localparam int B_UND   = 13;
  // control-only bits
  localparam int B_TRGEN = 16;
  localparam int B_SRST  = 28;

  localparam logic [31:0] STICKY_MASK = 32'h0000_3310;
  localparam logic [31:0] IRQ_MASK    = 32'h0000_3311;
  localparam logic [31:0] CTRL_MASK   = 32'h1001_3311;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CW-1:0]    cap,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic push_ok, pop_ok;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign level   = count;
  assign pop_data = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      count <= count + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};
    end
  end

  // R1
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> level == $past(level));
  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R2
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);
  // R11
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> level == '0);
endmodule

// File: rtl/sfi_status.sv
module sfi_status
  import spi_fifo_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic [31:0] set_evt,
  input  logic [31:0] clr_mask,
  input  logic [31:0] live_vec,
  input  logic [31:0] enables,
  output logic [31:0] status,
  output logic        irq
);
  logic [31:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sticky_q <= '0;
    else if (srst) sticky_q <= '0;
    else           sticky_q <= ((sticky_q & ~clr_mask) | set_evt) & STICKY_MASK;
  end

  assign status = sticky_q | (live_vec & ~STICKY_MASK);
  assign irq    = |(status & enables & IRQ_MASK);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ((sticky_q & $past(set_evt & STICKY_MASK)) == $past(set_evt & STICKY_MASK)));
  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> sticky_q == '0);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int FIFO_BYTES = 32,
  parameter int WORD_W     = 16,
  localparam int CW = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              wide_mode,
  input  logic              send_mode,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              xfer_end_evt,
  input  logic              shift_end_evt,
  output logic              irq
);
  localparam int CAP_NARROW = FIFO_BYTES;
  localparam int CAP_WIDE   = FIFO_BYTES / 2;

  logic [31:0] ctrl_q;
  logic [2:0]  trig_q;
  logic        srst;
  logic [CW-1:0] cap_sel, tx_level, rx_level;
  logic [WORD_W-1:0] dmask, rx_head;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_flush, rx_flush, tx_push, rx_pop;
  logic [31:0] set_vec, live_vec, clr_vec, stat;
  logic rx_trig;

  assign srst    = ctrl_q[B_SRST];
  assign cap_sel = wide_mode ? CW'(CAP_WIDE) : CW'(CAP_NARROW);
  assign dmask   = wide_mode ? {WORD_W{1'b1}} : WORD_W'(8'hFF);

  // register-side strobes
  assign tx_push  = reg_wr && (reg_addr == A_TXDATA) && !srst;
  assign rx_pop   = reg_rd && (reg_addr == A_RXDATA);
  assign tx_flush = srst || (reg_wr && (reg_addr == A_TXLVL) && (reg_wdata == '0));
  assign rx_flush = srst || (reg_wr && (reg_addr == A_RXLVL) && (reg_wdata == '0));
  assign clr_vec  = (reg_wr && (reg_addr == A_STAT)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trig_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
      if (reg_addr == A_TRIG) trig_q <= reg_wdata[2:0];
    end
  end

  sfi_fifo #(.DEPTH(FIFO_BYTES), .WIDTH(WORD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap_sel),
    .push(tx_push), .push_data(reg_wdata[WORD_W-1:0] & dmask),
    .pop(tx_ready), .pop_data(tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty));

  sfi_fifo #(.DEPTH(FIFO_BYTES), .WIDTH(WORD_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap_sel),
    .push(rx_valid && !srst), .push_data(rx_data & dmask),
    .pop(rx_pop), .pop_data(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty));

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  // live receive threshold: count >= 2^code
  assign rx_trig = ctrl_q[B_TRGEN] &&
                   ({{(32-CW){1'b0}}, rx_level} >= (32'd1 << trig_q));

  always_comb begin
    set_vec = '0;
    set_vec[B_TXTRG] = tx_valid && tx_ready && (tx_level == CW'(1)) && !tx_flush;
    set_vec[B_XEND]  = xfer_end_evt;
    set_vec[B_SEND]  = shift_end_evt;
    set_vec[B_OVF]   = rx_valid && rx_full;
    set_vec[B_UND]   = send_mode && tx_ready && tx_empty;
    live_vec = '0;
    live_vec[B_RXTRG] = rx_trig;
  end

  sfi_status u_stat (
    .clk(clk), .rst_n(rst_n), .srst(srst), .set_evt(set_vec),
    .clr_mask(clr_vec), .live_vec(live_vec), .enables(ctrl_q),
    .status(stat), .irq(irq));

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_STAT:   reg_rdata = stat;
      A_TRIG:   reg_rdata = {29'd0, trig_q};
      A_TXLVL:  reg_rdata = {{(32-CW){1'b0}}, tx_level};
      A_RXLVL:  reg_rdata = {{(32-CW){1'b0}}, rx_level};
      A_RXDATA: reg_rdata = {{(32-WORD_W){1'b0}}, rx_head};
      default:  reg_rdata = '0;
    endcase
  end

  // R5
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !srst |=> stat[B_OVF]);
  // R6
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_mode && tx_ready && !tx_valid && !srst |=> stat[B_UND]);
  // R10
  srst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !tx_valid && rx_ready);
endmodule

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_wr, reg_rd, wide_mode, send_mode, tx_ready, rx_valid;
  logic xfer_end_evt, shift_end_evt;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic tx_valid, rx_ready, irq;
  logic [15:0] tx_data, rx_data;

  spi_fifo_irq u0 (.*);

  int checks = 0, errors = 0;
  int txq[$], rxq[$];
  int unsigned m_stat = 0, m_ctrl = 0, m_trig = 0;

  function automatic int capn();
    return wide_mode ? 16 : 32;
  endfunction
  function automatic int unsigned dmask();
    return wide_mode ? 32'hFFFF : 32'hFF;
  endfunction
  function automatic int unsigned m_status();
    int unsigned s = m_stat;
    if (m_ctrl[16] && rxq.size() >= (1 << m_trig)) s |= 1;
    return s;
  endfunction
  function automatic int unsigned exp_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_status();
      2: return m_trig;
      3: return txq.size();
      4: return rxq.size();
      6: return rxq.size() ? rxq[0] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    bit srst = m_ctrl[28];
    int cap = capn();
    bit txflush = srst || (reg_wr && reg_addr == 3 && reg_wdata == 0);
    bit rxflush = srst || (reg_wr && reg_addr == 4 && reg_wdata == 0);
    bit txpop = tx_ready && txq.size() > 0;
    bit txpush = reg_wr && reg_addr == 5 && !srst && txq.size() < cap;
    bit rxpush = rx_valid && !srst && rxq.size() < cap;
    bit rxpop = reg_rd && reg_addr == 6 && rxq.size() > 0;
    int unsigned setv = 0, clr = 0;
    if (txpop && txq.size() == 1 && !txflush) setv |= 32'h10;
    if (xfer_end_evt) setv |= 32'h100;
    if (shift_end_evt) setv |= 32'h200;
    if (rx_valid && rxq.size() >= cap) setv |= 32'h1000;
    if (send_mode && tx_ready && txq.size() == 0) setv |= 32'h2000;
    if (reg_wr && reg_addr == 1) clr = reg_wdata;
    m_stat = srst ? 0 : (((m_stat & ~clr) | setv) & 32'h3310);
    if (txflush) txq.delete();
    else begin
      if (txpop) void'(txq.pop_front());
      if (txpush) txq.push_back(reg_wdata & dmask());
    end
    if (rxflush) rxq.delete();
    else begin
      if (rxpop) void'(rxq.pop_front());
      if (rxpush) rxq.push_back(rx_data & dmask());
    end
    if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata & 32'h1001_3311;
    if (reg_wr && reg_addr == 2) m_trig = reg_wdata & 7;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R1", tx_valid, txq.size() > 0, "tx_valid");
    chk("R1", tx_data, txq.size() ? txq[0] : 0, "tx_data");
    chk("R5", rx_ready, rxq.size() < capn(), "rx_ready");
    chk("R9", irq, (m_status() & m_ctrl & 32'h3311) != 0, "irq");
  endtask

  task automatic wr(input int a, input int unsigned d);
    reg_wr = 1; reg_addr = a[2:0]; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rdx(input int a, input int unsigned exp, input string tag);
    reg_rd = 1; reg_addr = a[2:0];
    #1;
    chk(tag, reg_rdata, exp_rd(a), "rdata vs model");
    chk(tag, reg_rdata, exp, "rdata vs literal");
    step();
    reg_rd = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    wide_mode = 0; send_mode = 0; tx_ready = 0; rx_valid = 0; rx_data = 0;
    xfer_end_evt = 0; shift_end_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // reset state R2
    rdx(0, 0, "R2"); rdx(1, 0, "R2"); rdx(3, 0, "R2"); rdx(4, 0, "R2");

    // R1 byte-mode order and masking, R4 last pop
    wr(5, 32'h1A5); wr(5, 32'h0C3); wr(5, 32'h7F);
    rdx(3, 3, "R1");
    chk("R1", tx_data, 32'hA5, "head masked to byte");
    tx_ready = 1; step(); step(); step(); tx_ready = 0;
    rdx(1, 32'h10, "R4");
    // R8 write-1-clear
    wr(1, 32'h10); rdx(1, 0, "R8");

    // R1 capacity byte mode, R2 flush and nonzero write
    for (int i = 0; i < 33; i++) wr(5, i + 1);
    rdx(3, 32, "R1");
    chk("R1", tx_data, 1, "head after dropped push");
    wr(3, 5); rdx(3, 32, "R2");
    wr(3, 0); rdx(3, 0, "R2");

    // R1 capacity word mode
    wide_mode = 1;
    for (int i = 0; i < 17; i++) wr(5, 32'h1234 + i);
    rdx(3, 16, "R1");
    chk("R1", tx_data, 32'h1234, "word head");
    wr(3, 0);
    wide_mode = 0;

    // R3 receive threshold 2^2 = 4
    wr(2, 2); wr(0, 32'h10001);
    rx_valid = 1;
    for (int i = 0; i < 3; i++) begin rx_data = 16'h40 + 16'(i); step(); end
    rx_valid = 0;
    rdx(1, 0, "R3");
    rx_valid = 1; rx_data = 16'h43; step(); rx_valid = 0;
    rdx(1, 1, "R3");
    chk("R9", irq, 1, "irq from rx threshold");
    wr(1, 1); rdx(1, 1, "R3");
    rdx(6, 32'h40, "R11");
    rdx(1, 0, "R3");
    chk("R9", irq, 0, "irq after drop below threshold");
    wr(0, 0); wr(4, 0);

    // R5 overflow, stored data unchanged
    rx_valid = 1;
    for (int i = 0; i < 33; i++) begin rx_data = 16'h50 + 16'(i); step(); end
    rx_valid = 0;
    rdx(4, 32, "R5");
    rdx(1, 32'h1000, "R5");
    rdx(6, 32'h50, "R1");
    wr(4, 0); wr(1, 32'hFFFF);

    // R6 underrun, and none when not sending
    tx_ready = 1; step(); tx_ready = 0;
    rdx(1, 0, "R6");
    wr(0, 32'h2000);
    send_mode = 1; tx_ready = 1; step(); tx_ready = 0; send_mode = 0;
    rdx(1, 32'h2000, "R6");
    chk("R9", irq, 1, "irq on enabled underrun");
    wr(1, 32'h2000);

    // R7 events; R9 masked; R8 set beats clear
    xfer_end_evt = 1; step(); xfer_end_evt = 0;
    shift_end_evt = 1; step(); shift_end_evt = 0;
    rdx(1, 32'h300, "R7");
    chk("R9", irq, 0, "irq masked");
    xfer_end_evt = 1; wr(1, 32'h100); xfer_end_evt = 0;
    rdx(1, 32'h300, "R8");
    wr(1, 32'h300); rdx(1, 0, "R8");

    // R10 soft reset
    wr(5, 32'h11); wr(5, 32'h22);
    xfer_end_evt = 1; step(); xfer_end_evt = 0;
    wr(0, 32'h1000_0000);
    step();
    rdx(3, 0, "R10"); rdx(1, 0, "R10");
    wr(5, 32'h33); rdx(3, 0, "R10");
    rdx(0, 32'h1000_0000, "R10");
    wr(0, 0);

    // R11 empty read
    rdx(6, 0, "R11"); rdx(4, 0, "R11"); rdx(5, 0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule